// File: doc/BRIEF.md
# Privileged Command Trap Controller

This block sits in front of the command executor of a security coprocessor and decides, one command at a time, whether a command may run. It keeps a one-bit privilege register. The value 0 is the hypervisor ring and the value 1 is the guest ring. It also keeps an enable bit for the guest ring. Each opcode is sorted into one of two classes: ordinary or management. An ordinary command is always passed to the back end. A management command is passed only when the privilege register is 0.

A management command that arrives in the guest ring never reaches the back end. The block clears the privilege register, records the offending opcode in a sticky field and raises an interrupt request that carries a fixed vector. It then holds off all commands until the host acknowledges the interrupt. The host emulates the command by sending it again, and this time it runs because the ring is 0. When the host resumes the guest, it pulses a dedicated input that sets the ring back to 1.

Commands enter on a valid/ready handshake. `cmd_ready` is low only while an interrupt is pending. A command offered while ready is low is not consumed, and the sender must hold `cmd_valid` and `cmd_op` until the handshake completes. The back end sees a single-cycle strobe and has no back-pressure.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset, `ring` is 0, `lvl2_en` is 0, `intr` is 0, `exe_valid` is 0, `trap_op` is 0 and `cmd_ready` is 1.
- R2: Opcodes 0x10 through 0x19 are management commands and every other opcode is ordinary. The management opcodes are: 0x10 guest-ring on, 0x11 guest-ring off, 0x12 launch context, 0x13 resume context, 0x14 exit context, 0x15 clear context, 0x16 migrate, 0x17 start migration, 0x18 start import and 0x19 import. `exe_mgmt` reports the class of an executed command.
- R3: An accepted ordinary command produces `exe_valid`=1 with `exe_op` equal to the opcode in the cycle after acceptance, in either ring, with no trap.
- R4: An accepted management command while `ring`=0 executes in the same way as R3, with `exe_mgmt`=1.
- R5: An accepted management command while `ring`=1 does not execute. In the next cycle `ring` is 0, `intr` is 1, `intr_vec` equals the VECTOR parameter (default 0x2A) and `trap_op` holds the opcode.
- R6: `intr` stays high until a cycle with `intr_ack`=1 and is low in the cycle after that. `intr_ack` has no effect while `intr` is low.
- R7: After the acknowledge, the same management command sent again executes with `exe_mgmt`=1.
- R8: Executing 0x10 sets `lvl2_en` in the next cycle. Executing 0x11 clears `lvl2_en` and forces `ring` to 0. While `lvl2_en`=0, `ring` stays 0.
- R9: An `enter_guest` pulse sets `ring` to 1 in the next cycle only when `lvl2_en`=1, `intr`=0 and no trap or 0x11 execution happens in the same cycle. Otherwise the pulse is ignored.
- R10: `trap_op` changes only on a trap and is unaffected by acknowledges and executed commands.
- R11: `cmd_ready` is 0 exactly while `intr` is 1. A command offered while `cmd_ready` is 0 is not executed and not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | OP_W | Command opcode |
| enter_guest | input | 1 | Host request to switch to the guest ring |
| exe_valid | output | 1 | One-cycle execute strobe to the back end |
| exe_op | output | OP_W | Opcode to execute |
| exe_mgmt | output | 1 | Executed command is a management command |
| intr | output | 1 | Interrupt request toward the host |
| intr_vec | output | VEC_W | Interrupt vector number |
| intr_ack | input | 1 | Interrupt acknowledge pulse |
| ring | output | 1 | Privilege register (0 hypervisor, 1 guest) |
| lvl2_en | output | 1 | Guest ring enabled |
| trap_op | output | OP_W | Opcode of the most recent trapped command |

## Verification
The hardest situation to reach from the ports is a trap. A trap needs three things to happen in order: an executed 0x10, an `enter_guest` pulse that is not cancelled, and then a management opcode that is accepted in ring 1. Random stimulus rarely produces this sequence. The directed part of the bench builds the sequence, holds a command against a pending interrupt, acknowledges and resends the trapped opcode. The random part biases half of its opcodes into the management range and pulses `enter_guest` often, so that it reaches ring 1 again and again and meets traps together with acknowledges, disables and pulses in the same cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned OP_W_DEF  = 8;
  localparam int unsigned VEC_W_DEF = 8;
  localparam int unsigned N_MGMT_DEF = 10;
  localparam logic [OP_W_DEF-1:0] MGMT_BASE_DEF = 8'h10;

  // position of each management opcode relative to the base; order is decoded
  typedef enum int unsigned {
    MG_RING_ON  = 0,
    MG_RING_OFF = 1,
    MG_LAUNCH   = 2,
    MG_RESUME   = 3,
    MG_EXIT     = 4,
    MG_CLEAR    = 5,
    MG_MIGRATE  = 6,
    MG_MIG_INIT = 7,
    MG_IMP_INIT = 8,
    MG_IMPORT   = 9
  } mgmt_idx_e;
endpackage

// File: rtl/ptc_decode.sv
module ptc_decode #(
  parameter int unsigned OP_W = 8,
  parameter int unsigned N_MGMT = 10,
  parameter logic [OP_W-1:0] BASE = 8'h10
) (
  input  logic [OP_W-1:0]   op,
  output logic [N_MGMT-1:0] hit,
  output logic              mgmt
);
  for (genvar i = 0; i < N_MGMT; i++) begin : g_slot
    localparam logic [OP_W-1:0] CODE = BASE + OP_W'(i);
    assign hit[i] = (op == CODE);
  end

  assign mgmt = |hit;

  // R2: at most one management slot matches an opcode
  always_comb begin
    a_r2_single_class: assert ($onehot0(hit));
  end
endmodule

// File: rtl/ptc_ring.sv
module ptc_ring (
  input  logic clk,
  input  logic rst_n,
  input  logic trap,
  input  logic do_on,
  input  logic do_off,
  input  logic enter_guest,
  input  logic intr_pend,
  output logic ring,
  output logic lvl2_en
);
  logic ring_q, en_q;
  logic guest_go;

  assign guest_go = enter_guest && en_q && !intr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (do_on)  en_q <= 1'b1;
      if (do_off) en_q <= 1'b0;
      if (trap || do_off)  ring_q <= 1'b0;
      else if (guest_go)   ring_q <= 1'b1;
    end
  end

  assign ring    = ring_q;
  assign lvl2_en = en_q;

  // R8: guest ring disabled means privilege register at zero
  a_r8_off_forces_ring0: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl2_en |-> !ring);

  // R9: entering the guest ring needs the enable and a request
  a_r9_guest_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring) |-> $past(en_q) && $past(enter_guest) && !$past(intr_pend));

  // R5: a trap always leaves the register at zero
  a_r5_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !ring);
endmodule

// File: rtl/ptc_irq.sv
module ptc_irq #(
  parameter int unsigned OP_W = 8,
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h2A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap,
  input  logic [OP_W-1:0] op_in,
  input  logic            ack,
  output logic            intr,
  output logic [VEC_W-1:0] vec,
  output logic [OP_W-1:0] trap_op
);
  logic            pend_q;
  logic [OP_W-1:0] top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      top_q  <= '0;
    end else begin
      if (trap) begin
        pend_q <= 1'b1;
        top_q  <= op_in;
      end else if (ack && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign intr    = pend_q;
  assign vec     = VECTOR;
  assign trap_op = top_q;

  // R6: request held until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack |=> intr);

  // R6: acknowledge drops the request
  a_r6_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    intr && ack |=> !intr);

  // R10: recorded opcode only moves on a trap
  a_r10_sticky_op: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(trap_op));
endmodule

// File: rtl/ptc_issue.sv
module ptc_issue #(
  parameter int unsigned OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [OP_W-1:0] op_in,
  input  logic            mgmt_in,
  output logic            exe_valid,
  output logic [OP_W-1:0] exe_op,
  output logic            exe_mgmt
);
  logic            v_q, m_q;
  logic [OP_W-1:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      m_q  <= 1'b0;
      op_q <= '0;
    end else begin
      v_q <= fire;
      if (fire) begin
        op_q <= op_in;
        m_q  <= mgmt_in;
      end
    end
  end

  assign exe_valid = v_q;
  assign exe_op    = op_q;
  assign exe_mgmt  = m_q;
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int unsigned OP_W = ptc_pkg::OP_W_DEF,
  parameter int unsigned VEC_W = ptc_pkg::VEC_W_DEF,
  parameter int unsigned N_MGMT = ptc_pkg::N_MGMT_DEF,
  parameter logic [OP_W-1:0] MGMT_BASE = ptc_pkg::MGMT_BASE_DEF,
  parameter logic [VEC_W-1:0] VECTOR = 8'h2A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic             enter_guest,
  output logic             exe_valid,
  output logic [OP_W-1:0]  exe_op,
  output logic             exe_mgmt,
  output logic             intr,
  output logic [VEC_W-1:0] intr_vec,
  input  logic             intr_ack,
  output logic             ring,
  output logic             lvl2_en,
  output logic [OP_W-1:0]  trap_op
);
  import ptc_pkg::*;

  localparam int unsigned IDX_ON  = int'(MG_RING_ON);
  localparam int unsigned IDX_OFF = int'(MG_RING_OFF);

  logic [N_MGMT-1:0] hit;
  logic mgmt, accept, trap, fire, do_on, do_off;

  ptc_decode #(.OP_W(OP_W), .N_MGMT(N_MGMT), .BASE(MGMT_BASE)) u_dec (
    .op(cmd_op), .hit(hit), .mgmt(mgmt)
  );

  assign cmd_ready = !intr;
  assign accept    = cmd_valid && cmd_ready;
  assign trap      = accept && mgmt && ring;
  assign fire      = accept && !trap;
  assign do_on     = fire && hit[IDX_ON];
  assign do_off    = fire && hit[IDX_OFF];

  ptc_ring u_ring (
    .clk(clk), .rst_n(rst_n), .trap(trap), .do_on(do_on), .do_off(do_off),
    .enter_guest(enter_guest), .intr_pend(intr), .ring(ring), .lvl2_en(lvl2_en)
  );

  ptc_irq #(.OP_W(OP_W), .VEC_W(VEC_W), .VECTOR(VECTOR)) u_irq (
    .clk(clk), .rst_n(rst_n), .trap(trap), .op_in(cmd_op), .ack(intr_ack),
    .intr(intr), .vec(intr_vec), .trap_op(trap_op)
  );

  ptc_issue #(.OP_W(OP_W)) u_iss (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op_in(cmd_op), .mgmt_in(mgmt),
    .exe_valid(exe_valid), .exe_op(exe_op), .exe_mgmt(exe_mgmt)
  );

  // R5: management command in guest ring is trapped, not executed
  a_r5_trap_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && mgmt && ring |=>
      !exe_valid && intr && !ring && intr_vec == VECTOR && trap_op == $past(cmd_op));

  // R4: management command in hypervisor ring executes
  a_r4_ring0_exec: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && mgmt && !ring |=>
      exe_valid && exe_mgmt && exe_op == $past(cmd_op));

  // R3: ordinary command executes in either ring
  a_r3_plain_exec: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !mgmt |=>
      exe_valid && !exe_mgmt && exe_op == $past(cmd_op));

  // R11: nothing executes from a cycle without a handshake
  a_r11_no_handshake_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !exe_valid);
endmodule

// File: tb/tb_priv_trap_ctrl.sv
module tb_priv_trap_ctrl;
  localparam logic [7:0] VEC = 8'h2A;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, enter_guest, exe_valid, exe_mgmt;
  logic intr, intr_ack, ring, lvl2_en;
  logic [7:0] cmd_op, exe_op, intr_vec, trap_op;

  always #4 clk = ~clk;

  priv_trap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .enter_guest(enter_guest), .exe_valid(exe_valid),
    .exe_op(exe_op), .exe_mgmt(exe_mgmt), .intr(intr), .intr_vec(intr_vec),
    .intr_ack(intr_ack), .ring(ring), .lvl2_en(lvl2_en), .trap_op(trap_op)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  bit m_ring, m_en, m_intr, m_exe, m_mg;
  logic [7:0] m_trap, m_eop;

  function automatic bit is_mgmt(input logic [7:0] op);
    return (op >= 8'h10) && (op <= 8'h19);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string etag);
    chk(ring == m_ring, "R9", "ring", ring, m_ring);
    chk(lvl2_en == m_en, "R8", "lvl2_en", lvl2_en, m_en);
    chk(intr == m_intr, "R6", "intr", intr, m_intr);
    chk(cmd_ready == !m_intr, "R11", "cmd_ready", cmd_ready, !m_intr);
    chk(trap_op == m_trap, "R10", "trap_op", trap_op, m_trap);
    chk(exe_valid == m_exe, etag, "exe_valid", exe_valid, m_exe);
    if (m_exe) begin
      chk(exe_op == m_eop, etag, "exe_op", exe_op, m_eop);
      chk(exe_mgmt == m_mg, "R2", "exe_mgmt", exe_mgmt, m_mg);
    end
    if (m_intr) chk(intr_vec == VEC, "R5", "intr_vec", intr_vec, VEC);
  endtask

  task automatic step(input bit v, input logic [7:0] op, input bit eg, input bit ack);
    bit acc, sens, trp, fire, off;
    string etag;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; enter_guest = eg; intr_ack = ack;
    acc  = v && !m_intr;
    sens = is_mgmt(op);
    trp  = acc && sens && m_ring;
    fire = acc && !trp;
    off  = fire && op == 8'h11;
    if (v && m_intr) etag = "R11";
    else if (acc && sens) etag = m_ring ? "R5" : "R4";
    else etag = "R3";
    @(posedge clk);
    m_exe = fire;
    if (fire) begin m_eop = op; m_mg = sens; end
    if (trp || off) m_ring = 0;
    else if (eg && m_en && !m_intr) m_ring = 1;
    if (fire && op == 8'h10) m_en = 1;
    if (off) m_en = 0;
    if (trp) begin m_intr = 1; m_trap = op; end
    else if (ack && m_intr) m_intr = 0;
    #1;
    compare(etag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL WATCHDOG run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; enter_guest = 0; intr_ack = 0;
    m_ring = 0; m_en = 0; m_intr = 0; m_exe = 0; m_mg = 0; m_trap = 0; m_eop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk(ring == 0 && lvl2_en == 0 && intr == 0 && exe_valid == 0 && trap_op == 0 && cmd_ready == 1,
        "R1", "reset state", {ring, lvl2_en, intr, exe_valid, cmd_ready}, 5'b00001);

    // directed: ordinary op in ring 0, guest entry while disabled ignored
    step(1, 8'h05, 0, 0);
    step(0, 8'h00, 1, 0);
    chk(ring == 0, "R9", "enter_guest ignored when disabled", ring, 0);
    // enable, enter guest, ordinary op in ring 1
    step(1, 8'h10, 0, 0);
    step(0, 8'h00, 1, 0);
    step(1, 8'h3C, 0, 0);
    // sensitive exit in ring 1 traps
    step(1, 8'h14, 0, 0);
    chk(intr == 1 && exe_valid == 0 && ring == 0 && trap_op == 8'h14, "R5", "trap on exit",
        {intr, exe_valid, ring}, 3'b100);
    // held command and guest entry during pending interrupt
    step(1, 8'h07, 1, 0);
    step(1, 8'h07, 0, 0);
    chk(exe_valid == 0 && ring == 0, "R11", "held command not executed", exe_valid, 0);
    step(0, 8'h00, 0, 1);
    // resend trapped command
    step(1, 8'h14, 0, 0);
    chk(exe_valid && exe_mgmt && exe_op == 8'h14, "R7", "resent command executes", exe_op, 8'h14);
    step(0, 8'h00, 0, 1);
    chk(intr == 0, "R6", "ack while idle ignored", intr, 0);
    // guest again, trap migrate, ack, then disable in ring 0 with guest pulse
    step(0, 8'h00, 1, 0);
    step(1, 8'h16, 0, 0);
    step(0, 8'h00, 0, 1);
    step(1, 8'h11, 1, 0);
    chk(lvl2_en == 0 && ring == 0, "R8", "disable wins over guest entry", {lvl2_en, ring}, 0);
    chk(trap_op == 8'h16, "R10", "trap_op sticky", trap_op, 8'h16);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      bit v, eg, ack;
      v   = ($urandom % 10) < 6;
      op  = ($urandom % 2) ? 8'(8'h10 + ($urandom % 10)) : 8'($urandom);
      if (op == 8'h11 && ($urandom % 3) != 0) op = 8'h10;
      eg  = ($urandom % 2);
      ack = ($urandom % 10) < 3;
      step(v, op, eg, ack);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule